// File: doc/BRIEF.md
# Sticky Interrupt Flag Collector with Clock Watchdogs

This block gathers the interrupt conditions of a four-channel measurement front end into one sticky flag vector. It also drives a single active-high interrupt request from that vector. Each channel supplies two comparator results, one from a high threshold and one from a low threshold. Each channel also has a modulator clock. A watchdog on that clock reports a failure when the clock runs slower than one sixty-fourth of the system clock.

A flag is captured only when the global interrupt enable and the flag's own enable are both high. Once set, a flag stays set. A read of the interrupt register, signalled by a one-cycle strobe, clears a flag only if its source is inactive at that moment. A source that is still active keeps its flag, and so keeps the request asserted, through any number of reads. Software therefore reads again after the condition has gone away.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, all twelve flags and `irq` are low. The flag vector is laid out as follows: bits 3:0 hold the high-threshold flags of channels 0..3, bits 7:4 hold the low-threshold flags of channels 0..3, and bits 11:8 hold the clock-fail flags of channels 0..3.
- R2: A comparator flag becomes 1 at the clock edge where its source, `mie` and its own enable are all high. It is visible one cycle after the inputs are applied.
- R3: A comparator flag is not set while `mie` is low or while its own enable is low, whatever its source does.
- R4: A set flag stays set after its source goes inactive, for as long as no read strobe arrives.
- R5: A read strobe that arrives while a flag's source is still active leaves that flag set.
- R6: A read strobe that arrives while a flag's source is inactive, and while the flag is not being set again, clears the flag at that edge.
- R7: `irq` is high exactly when at least one flag is set.
- R8: A modulator clock whose rising edges are at most 64 system clocks apart never produces a failure. A clock with no rising edge for more than 64 system clocks, plus the 3-cycle synchronizer delay, produces a failure.
- R9: A clock-fail flag is set only while `mie` and that channel's fail enable are both high. While the fail enable is low, a stopped clock leaves the flag at 0.
- R10: A clock-fail flag stays set while the clock is still failing, even across reads. It clears only on a read that arrives after the clock has recovered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi | input | 4 | High-threshold comparator result per channel |
| cmp_lo | input | 4 | Low-threshold comparator result per channel |
| mod_clk | input | 4 | Modulator clock per channel, asynchronous |
| mie | input | 1 | Global interrupt enable |
| ie_hi | input | 4 | Enable of each high-threshold flag |
| ie_lo | input | 4 | Enable of each low-threshold flag |
| fail_ie | input | 4 | Enable of each clock-fail flag |
| irq_rd | input | 1 | One-cycle strobe marking a read of the interrupt register |
| flags | output | 12 | Sticky flag vector |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
The assertions assume the following about the inputs:
- The comparator results, enables and read strobe are synchronous to `clk` and hold steady around each rising edge.
- Only `mod_clk` may change at any time.

The stimulus keeps within this by changing every synchronous input only on the falling edge of `clk`. The bench also builds each modulator clock from whole numbers of system cycles, so the spacing between its edges is known exactly. This matters for the boundary runs, which use a period of exactly 64 cycles and one slightly longer.

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
  parameter int NCH      = 4,
  parameter int WD_LIMIT = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       cmp_hi,
  input  logic [NCH-1:0]       cmp_lo,
  input  logic [NCH-1:0]       mod_clk,
  input  logic                 mie,
  input  logic [NCH-1:0]       ie_hi,
  input  logic [NCH-1:0]       ie_lo,
  input  logic [NCH-1:0]       fail_ie,
  input  logic                 irq_rd,
  output logic [3*NCH-1:0]     flags,
  output logic                 irq
);
  localparam int NFLG = 3 * NCH;
  localparam int CW   = $clog2(WD_LIMIT + 1);

  logic [NCH-1:0] sync1, sync2, sync3;
  logic [NCH-1:0] mclk_rise, wd_fail;
  logic [CW-1:0]  wd_cnt [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= mod_clk;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign mclk_rise = sync2 & ~sync3;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_wd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             wd_cnt[ch] <= '0;
      else if (mclk_rise[ch])                 wd_cnt[ch] <= '0;
      else if (wd_cnt[ch] != CW'(WD_LIMIT))   wd_cnt[ch] <= wd_cnt[ch] + 1'b1;
    end
    assign wd_fail[ch] = (wd_cnt[ch] == CW'(WD_LIMIT));

    // R8: a fresh edge always leaves the channel healthy
    a_r8_edge_clears_fail: assert property (@(posedge clk) disable iff (!rst_n)
      mclk_rise[ch] |=> !wd_fail[ch]);
  end

  logic [NFLG-1:0] src_all, en_all, set_v, clr_v;
  assign src_all = {wd_fail, cmp_lo, cmp_hi};
  assign en_all  = {fail_ie, ie_lo, ie_hi};
  assign set_v   = src_all & en_all & {NFLG{mie}};
  assign clr_v   = {NFLG{irq_rd}} & ~src_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= set_v | (flags & ~clr_v);
  end

  assign irq = |flags;

  for (genvar i = 0; i < NFLG; i++) begin : g_chk
    a_r3_set_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[i]) |-> $past(mie && en_all[i] && src_all[i]));
    a_r5_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && src_all[i]) |=> flags[i]);
    a_r6_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(irq_rd && !src_all[i]));
  end
endmodule

// File: tb/irq_flag_unit_tb.sv
module irq_flag_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  cmp_hi = 0, cmp_lo = 0, ie_hi = 0, ie_lo = 0, fail_ie = 0;
  logic [3:0]  mclk = 0;
  logic        mie = 0, irq_rd = 0;
  logic [11:0] flags;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  int per [4] = '{8, 8, 8, 8};
  int ph  [4] = '{0, 0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .mod_clk(mclk),
    .mie(mie), .ie_hi(ie_hi), .ie_lo(ie_lo), .fail_ie(fail_ie), .irq_rd(irq_rd),
    .flags(flags), .irq(irq));

  always @(posedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (per[c] != 0) begin
        ph[c] = ph[c] + 1;
        if (ph[c] >= per[c] / 2) begin
          ph[c] = 0;
          mclk[c] <= ~mclk[c];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] next_cmp(logic [7:0] prev, logic [7:0] src, logic [7:0] en,
                                          logic m, logic rd);
    logic [7:0] set_b, clr_b;
    set_b = src & en & {8{m}};
    clr_b = {8{rd}} & ~src;
    return set_b | (prev & ~clr_b);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_pulse();
    irq_rd = 1;
    cyc(1);
    irq_rd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] model;
    process_start();
  end

  task automatic process_start();
    logic [7:0] model;
    cyc(3);
    chk(flags == 0 && irq == 0, "R1 reset", {flags, irq}, 0);
    rst_n = 1;
    cyc(20);
    chk(flags == 0 && irq == 0, "R1 idle after reset", {flags, irq}, 0);

    // R3: global enable low
    ie_hi = 4'hF; cmp_hi = 4'h1; mie = 0;
    cyc(1);
    chk(flags == 0, "R3 mie low", flags, 0);
    // R3: own enable low
    mie = 1; ie_hi = 4'h0;
    cyc(1);
    chk(flags == 0, "R3 own enable low", flags, 0);
    // R2 + R7
    ie_hi = 4'h1;
    cyc(1);
    chk(flags == 12'h001, "R2 hi ch0 set", flags, 12'h001);
    chk(irq == 1, "R7 irq with flag", irq, 1);
    cmp_hi = 0;
    cyc(3);
    chk(flags[0] == 1, "R4 sticky", flags[0], 1);
    // R5 / R6 on low ch1 (bit 5)
    ie_lo = 4'h2; cmp_lo = 4'h2;
    cyc(1);
    chk(flags[5] == 1, "R2 lo ch1 set at bit5", flags, 12'h021);
    irq_rd = 1;
    cyc(1);
    chk(flags == 12'h020, "R5 read while active keeps bit5, clears bit0", flags, 12'h020);
    irq_rd = 0; cmp_lo = 0;
    cyc(1);
    chk(flags[5] == 1, "R4 still held without read", flags[5], 1);
    irq_rd = 1;
    cyc(1);
    irq_rd = 0;
    chk(flags == 0, "R6 cleared after inactive read", flags, 0);
    chk(irq == 0, "R7 irq low with no flags", irq, 0);

    // random phase against model
    void'($urandom(32'h5eed_1234));
    model = 0;
    fail_ie = 4'hF;
    for (int k = 0; k < 2000; k++) begin
      cmp_hi = 4'($urandom); cmp_lo = 4'($urandom);
      ie_hi = 4'($urandom); ie_lo = 4'($urandom);
      mie = ($urandom % 4) != 0;
      irq_rd = ($urandom % 5) == 0;
      model = next_cmp(model, {cmp_lo, cmp_hi}, {ie_lo, ie_hi}, mie, irq_rd);
      cyc(1);
      chk(flags == {4'h0, model}, "R2/R3/R4/R5/R6 random", flags, {4'h0, model});
      chk(irq == (model != 0), "R7 random irq", irq, model != 0);
    end
    cmp_hi = 0; cmp_lo = 0; ie_hi = 0; ie_lo = 0; irq_rd = 0; mie = 1;
    read_pulse();
    cyc(1);
    chk(flags == 0, "R6 all cleared", flags, 0);

    // R8 boundary: period 64 healthy
    fail_ie = 4'hF;
    for (int c = 0; c < 4; c++) per[c] = 64;
    cyc(200);
    read_pulse();
    cyc(600);
    chk(flags[11:8] == 0, "R8 period 64 no fail", flags[11:8], 0);
    // R8: period 72 fails
    per[3] = 72;
    cyc(300);
    chk(flags[11] == 1, "R8 period 72 fails ch3", flags[11], 1);
    for (int c = 0; c < 4; c++) per[c] = 8;
    cyc(100);
    read_pulse();
    cyc(1);
    chk(flags == 0, "R10 cleared after recovery", flags, 0);

    // R9: fail enable low
    fail_ie = 4'b1101;
    per[1] = 0;
    cyc(100);
    chk(flags[9] == 0, "R9 fail enable low", flags[9], 0);
    chk(irq == 0, "R9 irq low", irq, 0);
    fail_ie = 4'hF;
    cyc(2);
    chk(flags[9] == 1, "R9 fail flag after enable", flags[9], 1);

    // R10: read while still failing
    per[2] = 0;
    cyc(100);
    chk(flags[10] == 1, "R8 stopped ch2 fails", flags[10], 1);
    read_pulse();
    cyc(1);
    chk(flags[10:9] == 2'b11, "R10 read while failing keeps", flags[10:9], 2'b11);
    per[1] = 8; per[2] = 8;
    cyc(30);
    chk(flags[10:9] == 2'b11, "R10 recovered but not read", flags[10:9], 2'b11);
    read_pulse();
    cyc(1);
    chk(flags == 0 && irq == 0, "R10 cleared on read after recovery", {flags, irq}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask
endmodule